// File: doc/BRIEF.md
# Six-State Branching Register Machine

This block is a small finite-state machine with a datapath. Three data registers, A, B and C, are updated under control of a state number that runs from 0 to 5. In each state one group of register assignments happens in a single clock. Three condition inputs choose between the alternative assignments and the alternative next states. The operations are sums, an increment, a three-way sum plus one, and bitwise complements. All sums wrap modulo 2^W.

While idle in state 0, the block accepts initial register values through a load port that uses a valid/ready handshake. The port is ready only in state 0 and only when start is low. A load is taken on a clock edge where both ld_valid and ld_ready are high. When ld_ready is low, the producer must hold its data until the port becomes ready again. A start pulse begins one pass through the graph. The done output pulses for one cycle after the machine leaves state 5 and returns to state 0. The register contents and the state number are visible on output ports at all times.

Top module: `branch_fsmd`

## Requirements
- R1: While rst_n is low, the state reads 0, all three registers read 0, done reads 0 and ld_ready reads 1.
- R2: In state 0 with start low, ld_ready is 1. A clock edge with ld_valid high loads ld_a, ld_b and ld_c into A, B and C. Without ld_valid, the registers and the state hold.
- R3: In state 0 with start high, ld_ready is 0 and any offered load is ignored. The next edge sets A to B+C and moves to state 1. ld_ready is 0 in states 1 to 5.
- R4: In state 1, x_a=0 sets A to A+1 and moves to state 4. x_a=1 sets B to B+C and moves to state 2.
- R5: In state 2, x_b=1 sets C to A+B and moves to state 5. x_b=0 sets C to the bitwise complement of C and moves to state 3.
- R6: In state 3, x_c=1 sets A to C+B. x_c=0 complements C. Both cases move to state 5.
- R7: In state 4, B is complemented. If x_a=0 and x_c=0, A is set in the same edge to A+B+C+1, computed from the values held before that edge. Otherwise A holds. The next state is 5.
- R8: State 5 moves to state 0. done is 1 exactly in the one cycle after a cycle spent in state 5, and 0 at all other times.
- R9: A register that a state does not assign holds its value. All arithmetic wraps modulo 2^W. state_o carries the state number in binary. Conditions that a state does not consult have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins one pass when seen in state 0 |
| x_a | input | 1 | Condition input consulted in states 1 and 4 |
| x_b | input | 1 | Condition input consulted in state 2 |
| x_c | input | 1 | Condition input consulted in states 3 and 4 |
| ld_valid | input | 1 | Load data offered |
| ld_ready | output | 1 | Load port can accept (state 0, start low) |
| ld_a | input | W | Initial value for A |
| ld_b | input | W | Initial value for B |
| ld_c | input | W | Initial value for C |
| reg_a | output | W | Current value of A |
| reg_b | output | W | Current value of B |
| reg_c | output | W | Current value of C |
| state_o | output | 3 | Current state number |
| done | output | 1 | One-cycle pulse after leaving state 5 |

## Verification
Every register and state result is due on the first rising edge after the cycle in which the state and the condition inputs were presented. done is due one edge after the cycle in state 5. ld_ready follows start and the state with no register in between. The bench drives inputs on the falling edge and samples one time unit after each rising edge. It checks ld_ready shortly after driving start. It steps its own arithmetic model once per edge, so each comparison lines up with the edge that produced the value.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;

  localparam int NREG  = 3;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;
  localparam int SW    = 3;

  typedef enum logic [SW-1:0] {
    ST_0 = 3'd0,
    ST_1 = 3'd1,
    ST_2 = 3'd2,
    ST_3 = 3'd3,
    ST_4 = 3'd4,
    ST_5 = 3'd5
  } fsm_state_e;

  // Source select for one register's next value
  typedef enum logic [2:0] {
    SEL_KEEP     = 3'd0,
    SEL_EXT      = 3'd1,
    SEL_SUM_BC   = 3'd2,
    SEL_INC      = 3'd3,
    SEL_SUM_AB   = 3'd4,
    SEL_SUM_ABC1 = 3'd5,
    SEL_INV      = 3'd6
  } src_sel_e;

endpackage

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
  import fsmd_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      x_a,
  input  logic                      x_b,
  input  logic                      x_c,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  output fsm_state_e                state,
  output src_sel_e [NREG-1:0]       sel,
  output logic                      done
);

  fsm_state_e state_nxt;

  assign ld_ready = (state == ST_0) && !start;

  always_comb begin
    state_nxt = state;
    for (int i = 0; i < NREG; i++) sel[i] = SEL_KEEP;
    case (state)
      ST_0: begin
        if (start) begin
          sel[IDX_A] = SEL_SUM_BC;
          state_nxt  = ST_1;
        end else if (ld_valid) begin
          for (int i = 0; i < NREG; i++) sel[i] = SEL_EXT;
        end
      end
      ST_1: begin
        if (x_a) begin
          sel[IDX_B] = SEL_SUM_BC;
          state_nxt  = ST_2;
        end else begin
          sel[IDX_A] = SEL_INC;
          state_nxt  = ST_4;
        end
      end
      ST_2: begin
        if (x_b) begin
          sel[IDX_C] = SEL_SUM_AB;
          state_nxt  = ST_5;
        end else begin
          sel[IDX_C] = SEL_INV;
          state_nxt  = ST_3;
        end
      end
      ST_3: begin
        if (x_c) sel[IDX_A] = SEL_SUM_BC;
        else     sel[IDX_C] = SEL_INV;
        state_nxt = ST_5;
      end
      ST_4: begin
        sel[IDX_B] = SEL_INV;
        if (!x_a && !x_c) sel[IDX_A] = SEL_SUM_ABC1;
        state_nxt = ST_5;
      end
      ST_5: state_nxt = ST_0;
      default: state_nxt = ST_0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_0;
      done  <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= (state == ST_5);
    end
  end

endmodule

// File: rtl/fsmd_alu.sv
module fsmd_alu
  import fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [NREG-1:0][W-1:0] cur,
  input  logic [NREG-1:0][W-1:0] ext,
  input  src_sel_e [NREG-1:0]    sel,
  output logic [NREG-1:0][W-1:0] nxt,
  output logic [NREG-1:0]        wr
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] sum_bc;
  logic [W-1:0] sum_ab;
  logic [W-1:0] sum_abc1;

  assign sum_bc   = cur[IDX_B] + cur[IDX_C];
  assign sum_ab   = cur[IDX_A] + cur[IDX_B];
  assign sum_abc1 = cur[IDX_A] + cur[IDX_B] + cur[IDX_C] + ONE;

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    always_comb begin
      wr[i]  = 1'b1;
      nxt[i] = cur[i];
      case (sel[i])
        SEL_EXT:      nxt[i] = ext[i];
        SEL_SUM_BC:   nxt[i] = sum_bc;
        SEL_INC:      nxt[i] = cur[i] + ONE;
        SEL_SUM_AB:   nxt[i] = sum_ab;
        SEL_SUM_ABC1: nxt[i] = sum_abc1;
        SEL_INV:      nxt[i] = ~cur[i];
        default:      wr[i]  = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fsmd_regs.sv
module fsmd_regs
  import fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        wr,
  input  logic [NREG-1:0][W-1:0] nxt,
  output logic [NREG-1:0][W-1:0] q
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (wr[i]) q[i] <= nxt[i];
    end
  end

endmodule

// File: rtl/branch_fsmd.sv
module branch_fsmd
  import fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         x_a,
  input  logic         x_b,
  input  logic         x_c,
  input  logic         ld_valid,
  output logic         ld_ready,
  input  logic [W-1:0] ld_a,
  input  logic [W-1:0] ld_b,
  input  logic [W-1:0] ld_c,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic [2:0]   state_o,
  output logic         done
);

  fsm_state_e             state;
  src_sel_e [NREG-1:0]    sel;
  logic [NREG-1:0][W-1:0] cur;
  logic [NREG-1:0][W-1:0] ext;
  logic [NREG-1:0][W-1:0] nxt;
  logic [NREG-1:0]        wr;

  assign ext[IDX_A] = ld_a;
  assign ext[IDX_B] = ld_b;
  assign ext[IDX_C] = ld_c;

  fsmd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .x_a      (x_a),
    .x_b      (x_b),
    .x_c      (x_c),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .state    (state),
    .sel      (sel),
    .done     (done)
  );

  fsmd_alu #(.W(W)) u_alu (
    .cur (cur),
    .ext (ext),
    .sel (sel),
    .nxt (nxt),
    .wr  (wr)
  );

  fsmd_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .nxt   (nxt),
    .q     (cur)
  );

  assign reg_a   = cur[IDX_A];
  assign reg_b   = cur[IDX_B];
  assign reg_c   = cur[IDX_C];
  assign state_o = state;

endmodule

// File: rtl/branch_fsmd_chk.sv
module branch_fsmd_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         x_a,
  input logic         x_c,
  input logic         ld_valid,
  input logic         ld_ready,
  input logic [W-1:0] ld_a,
  input logic [W-1:0] ld_b,
  input logic [W-1:0] ld_c,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] reg_c,
  input logic [2:0]   state_o,
  input logic         done
);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (state_o == 3'd0) && !start);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (reg_a == $past(ld_a)) && (reg_b == $past(ld_b))
                               && (reg_c == $past(ld_c)) && (state_o == 3'd0));

  // R3
  start_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && start) |=> (state_o == 3'd1)
                                   && (reg_a == $past(reg_b) + $past(reg_c)));

  // R4
  inc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !x_a) |=> (state_o == 3'd4) && (reg_a == $past(reg_a) + 1'b1)
                                  && $stable(reg_b) && $stable(reg_c));

  // R6
  c_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !x_c) |=> (state_o == 3'd5) && (reg_c == ~$past(reg_c))
                                  && $stable(reg_a));

  // R7
  b_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |=> (state_o == 3'd5) && (reg_b == ~$past(reg_b)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |=> done && (state_o == 3'd0));

  // R8
  done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state_o) == 3'd5));

  // R9
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

endmodule

bind branch_fsmd branch_fsmd_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .x_a      (x_a),
  .x_c      (x_c),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .ld_a     (ld_a),
  .ld_b     (ld_b),
  .ld_c     (ld_c),
  .reg_a    (reg_a),
  .reg_b    (reg_b),
  .reg_c    (reg_c),
  .state_o  (state_o),
  .done     (done)
);

// File: tb/branch_fsmd_tb_top.sv
module branch_fsmd_tb_top;

  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MK         = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, x_a, x_b, x_c, ld_valid, ld_ready, done;
  logic [W-1:0] ld_a, ld_b, ld_c, reg_a, reg_b, reg_c;
  logic [2:0]   state_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_fsmd #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .x_a(x_a), .x_b(x_b), .x_c(x_c),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .state_o(state_o), .done(done)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // One pass: load, start, then walk the graph with per-state condition bits
  task automatic run(int a0, int b0, int c0, int code);
    int q, a, b, c, nq, na, nb, nc;
    bit xa, xb, xc, prev5;
    string tag;
    @(negedge clk);
    start = 0; ld_valid = 1;
    ld_a = W'(a0); ld_b = W'(b0); ld_c = W'(c0);
    @(posedge clk); #1;
    check("R2", "load A", int'(reg_a), a0);
    check("R2", "load B", int'(reg_b), b0);
    check("R2", "load C", int'(reg_c), c0);
    @(negedge clk);
    // offer junk data together with start: it must be refused
    start = 1; ld_valid = 1;
    ld_a = W'(~a0); ld_b = W'(a0); ld_c = W'(b0);
    #1;
    check("R3", "ld_ready with start", int'(ld_ready), 0);
    q = 0; a = a0; b = b0; c = c0;
    prev5 = 0;
    for (int step = 0; step < 8 && !prev5; step++) begin
      case (q)
        1: begin xa = code[0]; xb = code[3]; xc = code[4]; end
        2: begin xb = code[1]; xa = code[3]; xc = code[4]; end
        3: begin xc = code[2]; xa = code[3] ^ code[4]; xb = code[0]; end
        4: begin xa = code[3]; xc = code[4]; xb = code[1]; end
        default: begin xa = code[1]; xb = code[2]; xc = code[0]; end
      endcase
      x_a = xa; x_b = xb; x_c = xc;
      na = a; nb = b; nc = c; nq = q;
      case (q)
        0: begin na = (b + c) & MK; nq = 1; tag = "R3 R9"; end
        1: begin
          if (xa) begin nb = (b + c) & MK; nq = 2; end
          else    begin na = (a + 1) & MK; nq = 4; end
          tag = "R4 R9";
        end
        2: begin
          if (xb) begin nc = (a + b) & MK; nq = 5; end
          else    begin nc = ~c & MK;      nq = 3; end
          tag = "R5 R9";
        end
        3: begin
          if (xc) na = (c + b) & MK;
          else    nc = ~c & MK;
          nq = 5; tag = "R6 R9";
        end
        4: begin
          nb = ~b & MK;
          if (!xa && !xc) na = (a + b + c + 1) & MK;
          nq = 5; tag = "R7 R9";
        end
        default: begin nq = 0; tag = "R8"; end
      endcase
      if (q != 0) begin
        #1;
        check("R3", "ld_ready busy", int'(ld_ready), 0);
      end
      @(posedge clk); #1;
      check(tag, "state", int'(state_o), nq);
      check(tag, "A", int'(reg_a), na);
      check(tag, "B", int'(reg_b), nb);
      check(tag, "C", int'(reg_c), nc);
      check("R8", "done", int'(done), (q == 5) ? 1 : 0);
      prev5 = (q == 5);
      q = nq; a = na; b = nb; c = nc;
      @(negedge clk);
      start = 0; ld_valid = 0;
    end
    // idle: nothing offered, everything holds
    x_a = code[0]; x_b = code[1]; x_c = code[2];
    #1;
    check("R2", "ld_ready idle", int'(ld_ready), 1);
    @(posedge clk); #1;
    check("R2", "idle state", int'(state_o), 0);
    check("R2", "idle A", int'(reg_a), a);
    check("R2", "idle B", int'(reg_b), b);
    check("R2", "idle C", int'(reg_c), c);
    check("R8", "done after idle", int'(done), 0);
  endtask

  initial begin
    rst_n = 0; start = 0; x_a = 0; x_b = 0; x_c = 0;
    ld_valid = 1; ld_a = '1; ld_b = '1; ld_c = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "reset state", int'(state_o), 0);
    check("R1", "reset A", int'(reg_a), 0);
    check("R1", "reset B", int'(reg_b), 0);
    check("R1", "reset C", int'(reg_c), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset ld_ready", int'(ld_ready), 1);
    ld_valid = 0;
    rst_n = 1;
    for (int a0 = 0; a0 <= MK; a0 += 5)
      for (int b0 = 0; b0 <= MK; b0 += 5)
        for (int c0 = 0; c0 <= MK; c0 += 5)
          for (int code = 0; code < 32; code++)
            run(a0, b0, c0, code);
    summary();
  end

endmodule